// File: doc/BRIEF.md
# PLL Cycle-Count Lock Monitor

This block sits next to a PLL phase detector and decides whether the loop is locked. It watches the reference clock and the feedback clock that reach the phase detector. The reference side is pre-divided by a programmable divide factor. The block counts edges from both sides over a measurement window. When the two counts disagree by one whole cycle or more, the lock flag drops and a one-cycle loss event is raised. The block keeps measuring after a loss. It raises the lock flag again once enough consecutive windows show no difference.

The feedback clock is asynchronous to the reference. Its edges are counted in the feedback domain with a Gray-coded counter. That count crosses into the reference domain through a two-flop synchronizer and is decoded to binary there. All decisions are made in the reference clock domain.

The cycle-count comparison only applies at multiplication factors above a fine-range limit. At or below that limit, a separate fine-skew detector outside this block is responsible, so every window is treated as matched. A load strobe captures a new multiplication factor and a new divide factor. The divide factor is used at once. The new multiplication factor, and with it the detection mode, takes effect only after a first window whose result is discarded.

Top module: `pll_lock_monitor`

## Requirements
- R1: While reset is asserted (rst_n low), `locked` and `loss_pulse` are 0. Reset leaves an active multiplication factor of 0, an active divide factor of 0, and a discarded first window.
- R2: A window lasts WIN_TICKS×(D+1) reference cycles, where D is the active divide factor. A window matches when exactly WIN_TICKS feedback rising edges arrive in it.
- R3: When the active multiplication factor exceeds FINE_MF_MAX and a window does not match while `locked` is 1, `locked` falls. In that same cycle `loss_pulse` is 1. The change is seen two cycles after the window's last cycle.
- R4: When the active multiplication factor is FINE_MF_MAX or less (default 4), the count comparison is bypassed. Every window counts as matched, so no loss is ever raised, and an unlocked monitor relocks on window count alone.
- R5: While unlocked, `locked` rises after RELOCK_WINS consecutive matched windows (default 16).
- R6: A non-matching window while unlocked raises no `loss_pulse`. It restarts the consecutive-match count from zero.
- R7: A cycle with `load` high applies `div_factor` from the next window on and restarts the window. The first window after a load, like the first after reset, is discarded. The loaded `mult_factor` becomes active only at the end of that discarded window. A load by itself does not change `locked`.
- R8: `loss_pulse` is high for exactly one reference cycle, and only in the cycle where `locked` falls. Every fall of `locked` carries that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all decisions and outputs are in this domain |
| fb_clk | input | 1 | Divided feedback clock from the loop |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Captures `mult_factor` and `div_factor` (ref_clk domain) |
| mult_factor | input | MF_W | New multiplication factor |
| div_factor | input | DF_W | New reference divide factor (divide by value+1) |
| locked | output | 1 | Lock status flag |
| loss_pulse | output | 1 | One-cycle pulse when lock is lost |

## Verification
The bench shortens the window to WIN_TICKS=8 and keeps the default relock count of 16. With divide factors 1 to 3, each window is 16 to 32 reference cycles, so a full relock after reset or after a loss takes a few hundred cycles. This leaves room to step through each mode switch in turn. The feedback clock comes from a bench divider with a fixed phase against the reference. Under lock, every window count is therefore exact. A single dropped feedback edge is then a deterministic one-cycle discrepancy that lands in a chosen window. The multiplication factors 4 and 5 sit on either side of the fine-range limit and show the bypass boundary. Loading a divide factor that the feedback rate does not follow shows when the new factors take effect.

// File: rtl/lockmon_pkg.sv
`timescale 1ns/1ps
package lockmon_pkg;

  // Binary to reflected Gray code
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Reflected Gray code back to binary
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // Number of reference cycles in one measurement window
  function automatic int unsigned win_len(input int unsigned div_f,
                                          input int unsigned ticks);
    return (div_f + 1) * ticks;
  endfunction

  // Multiplication factors in this range are left to the fine-skew detector
  function automatic logic in_fine_range(input int unsigned mult_f,
                                         input int unsigned fine_max);
    return mult_f <= fine_max;
  endfunction

  typedef struct packed {
    logic valid;  // a window result is present this cycle
    logic miss;   // that window did not match
  } win_result_t;

endpackage

// File: rtl/lockmon_fb_counter.sv
`timescale 1ns/1ps
module lockmon_fb_counter #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             fb_clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] gray_q
);
  import lockmon_pkg::*;

  logic [1:0]       rst_sync;
  logic             fb_rst_n;
  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_next;

  // local reset release aligned to the feedback clock
  always_ff @(posedge fb_clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign fb_rst_n = rst_sync[1];

  assign bin_next = bin_q + 1'b1;

  always_ff @(posedge fb_clk or negedge fb_rst_n) begin
    if (!fb_rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_next;
      gray_q <= CNT_W'(to_gray(32'(bin_next)));
    end
  end
endmodule

// File: rtl/lockmon_gray_sync.sv
`timescale 1ns/1ps
module lockmon_gray_sync #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] gray_in,
  output logic [CNT_W-1:0] bin_out
);
  import lockmon_pkg::*;

  logic [CNT_W-1:0] stage1;
  logic [CNT_W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  assign bin_out = CNT_W'(from_gray(32'(stage2)));
endmodule

// File: rtl/lockmon_window.sv
`timescale 1ns/1ps
module lockmon_window #(
  parameter int unsigned MF_W        = 12,
  parameter int unsigned DF_W        = 4,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned POS_W       = 9,
  parameter int unsigned WIN_TICKS   = 16,
  parameter int unsigned FINE_MF_MAX = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [MF_W-1:0]            mf_in,
  input  logic [DF_W-1:0]            df_in,
  input  logic [CNT_W-1:0]           fb_cnt,
  output lockmon_pkg::win_result_t   result,
  output logic                       bypass,
  output logic [POS_W-1:0]           pos_o,
  output logic                       settle_o
);
  import lockmon_pkg::*;

  localparam logic [CNT_W-1:0] EXP_EDGES = CNT_W'(WIN_TICKS);

  logic [DF_W-1:0]  df_act;
  logic [MF_W-1:0]  mf_act;
  logic [MF_W-1:0]  mf_pend;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] last_pos;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] delta;
  logic             settle;
  logic             boundary;

  assign last_pos = POS_W'(win_len(32'(df_act), WIN_TICKS) - 1);
  assign boundary = (pos == last_pos);
  assign delta    = fb_cnt - base;
  assign bypass   = in_fine_range(32'(mf_act), FINE_MF_MAX);

  // window position, factor registers and the discarded first window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      df_act  <= '0;
      mf_act  <= '0;
      mf_pend <= '0;
      pos     <= '0;
      base    <= '0;
      settle  <= 1'b1;
    end else if (load) begin
      df_act  <= df_in;       // divider changes first
      mf_pend <= mf_in;       // multiplier waits for the settle window
      pos     <= '0;
      base    <= fb_cnt;
      settle  <= 1'b1;
    end else if (boundary) begin
      pos  <= '0;
      base <= fb_cnt;
      if (settle) begin
        settle <= 1'b0;
        mf_act <= mf_pend;
      end
    end else begin
      pos <= pos + 1'b1;
    end
  end

  // registered verdict of the window that just closed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
    end else begin
      result.valid <= boundary && !settle && !load;
      result.miss  <= (delta != EXP_EDGES) && !bypass;
    end
  end

  assign pos_o    = pos;
  assign settle_o = settle;
endmodule

// File: rtl/lockmon_lock_fsm.sv
`timescale 1ns/1ps
module lockmon_lock_fsm #(
  parameter int unsigned RELOCK_WINS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  lockmon_pkg::win_result_t result,
  output logic                     locked,
  output logic                     loss_pulse
);
  localparam int unsigned SW = $clog2(RELOCK_WINS + 1);
  localparam logic [SW-1:0] STREAK_LAST = SW'(RELOCK_WINS - 1);

  logic [SW-1:0] streak;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked     <= 1'b0;
      loss_pulse <= 1'b0;
      streak     <= '0;
    end else begin
      loss_pulse <= 1'b0;
      if (result.valid) begin
        if (result.miss) begin
          streak <= '0;
          if (locked) begin
            locked     <= 1'b0;
            loss_pulse <= 1'b1;
          end
        end else if (!locked) begin
          if (streak == STREAK_LAST) begin
            locked <= 1'b1;
            streak <= '0;
          end else begin
            streak <= streak + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pll_lock_monitor.sv
`timescale 1ns/1ps
module pll_lock_monitor #(
  parameter int unsigned MF_W        = 12,
  parameter int unsigned DF_W        = 4,
  parameter int unsigned WIN_TICKS   = 16,
  parameter int unsigned RELOCK_WINS = 16,
  parameter int unsigned FINE_MF_MAX = 4
) (
  input  logic            ref_clk,
  input  logic            fb_clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MF_W-1:0] mult_factor,
  input  logic [DF_W-1:0] div_factor,
  output logic            locked,
  output logic            loss_pulse
);
  import lockmon_pkg::*;

  localparam int unsigned CNT_W = $clog2(WIN_TICKS) + 4;
  localparam int unsigned POS_W = DF_W + $clog2(WIN_TICKS) + 1;

  logic [CNT_W-1:0] fb_gray_w;
  logic [CNT_W-1:0] fb_cnt_w;
  win_result_t      result_w;
  logic             bypass_w;
  logic [POS_W-1:0] win_pos_w;
  logic             settle_w;

  lockmon_fb_counter #(.CNT_W(CNT_W)) u_fb_cnt (
    .fb_clk (fb_clk),
    .rst_n  (rst_n),
    .gray_q (fb_gray_w)
  );

  lockmon_gray_sync #(.CNT_W(CNT_W)) u_sync (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .gray_in (fb_gray_w),
    .bin_out (fb_cnt_w)
  );

  lockmon_window #(
    .MF_W(MF_W), .DF_W(DF_W), .CNT_W(CNT_W), .POS_W(POS_W),
    .WIN_TICKS(WIN_TICKS), .FINE_MF_MAX(FINE_MF_MAX)
  ) u_win (
    .clk      (ref_clk),
    .rst_n    (rst_n),
    .load     (load),
    .mf_in    (mult_factor),
    .df_in    (div_factor),
    .fb_cnt   (fb_cnt_w),
    .result   (result_w),
    .bypass   (bypass_w),
    .pos_o    (win_pos_w),
    .settle_o (settle_w)
  );

  lockmon_lock_fsm #(.RELOCK_WINS(RELOCK_WINS)) u_fsm (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .result     (result_w),
    .locked     (locked),
    .loss_pulse (loss_pulse)
  );
endmodule

// File: rtl/lockmon_checker.sv
`timescale 1ns/1ps
module lockmon_checker #(
  parameter int unsigned POS_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             locked,
  input logic             loss_pulse,
  input logic             bypass_w,
  input logic             res_valid,
  input logic             res_miss,
  input logic [POS_W-1:0] win_pos_w,
  input logic             settle_w
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (!locked && !loss_pulse));

  p_pulse_drops_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    loss_pulse |-> (!locked && $past(locked)));

  p_bypass_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loss_pulse |-> !$past(bypass_w));

  p_rise_after_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(res_valid && !res_miss));

  p_load_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (win_pos_w == '0) && settle_w);

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loss_pulse |=> !loss_pulse);

  p_fall_has_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> loss_pulse);

endmodule

bind pll_lock_monitor lockmon_checker #(.POS_W(POS_W)) u_chk (
  .clk        (ref_clk),
  .rst_n      (rst_n),
  .load       (load),
  .locked     (locked),
  .loss_pulse (loss_pulse),
  .bypass_w   (bypass_w),
  .res_valid  (result_w.valid),
  .res_miss   (result_w.miss),
  .win_pos_w  (win_pos_w),
  .settle_w   (settle_w)
);

// File: tb/tb_pll_lock_monitor.sv
`timescale 1ns/1ps
module tb_pll_lock_monitor;
  localparam int unsigned MF_W = 12;
  localparam int unsigned DF_W = 4;
  localparam int unsigned WTK  = 8;
  localparam int unsigned RWIN = 16;

  typedef enum int {EV_LOCK, EV_LOSS} ev_t;

  logic            clk = 1'b0;
  logic            fb_clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            load = 1'b0;
  logic [MF_W-1:0] mult = '0;
  logic [DF_W-1:0] divf = '0;
  logic            locked;
  logic            loss_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int fb_div = 2;
  int fb_ph = 0;
  bit skip_req = 1'b0;
  bit done = 1'b0;
  ev_t   ev_q[$];
  string tag_q[$];
  logic  prev_locked = 1'b0;
  logic  prev_pulse = 1'b0;

  pll_lock_monitor #(
    .MF_W(MF_W), .DF_W(DF_W), .WIN_TICKS(WTK),
    .RELOCK_WINS(RWIN), .FINE_MF_MAX(4)
  ) dut (
    .ref_clk(clk), .fb_clk(fb_clk), .rst_n(rst_n), .load(load),
    .mult_factor(mult), .div_factor(divf),
    .locked(locked), .loss_pulse(loss_pulse)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // feedback clock: one high ref cycle per fb_div cycles, fixed phase
  always @(posedge clk) begin
    #3;
    if (fb_ph == 0) begin
      if (skip_req) begin
        skip_req = 1'b0;
        fb_clk = 1'b0;
      end else begin
        fb_clk = 1'b1;
      end
    end else begin
      fb_clk = 1'b0;
    end
    fb_ph = (fb_ph + 1 >= fb_div) ? 0 : fb_ph + 1;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic at_cycle(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic expect_ev(input ev_t e, input string tag);
    ev_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic do_load(input int mf, input int df, input int new_fb, output int l);
    @(negedge clk);
    mult = MF_W'(mf);
    divf = DF_W'(df);
    load = 1'b1;
    if (new_fb > 0) fb_div = new_fb;
    l = cyc + 1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // scoreboard monitor: compares observed events against the expected queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (loss_pulse && prev_pulse) begin
        checks++; errors++;
        $display("FAIL R8 pulse width actual=2+ expected=1 at cycle %0d", cyc);
      end
      if (loss_pulse || (locked && !prev_locked)) begin
        ev_t seen;
        seen = loss_pulse ? EV_LOSS : EV_LOCK;
        checks++;
        if (ev_q.size() == 0) begin
          errors++;
          $display("FAIL unexpected event actual=%s expected=none at cycle %0d",
                   seen.name(), cyc);
        end else begin
          ev_t want;
          string t;
          want = ev_q.pop_front();
          t = tag_q.pop_front();
          if (want != seen) begin
            errors++;
            $display("FAIL %s event actual=%s expected=%s", t, seen.name(), want.name());
          end
        end
        if (loss_pulse && (locked || !prev_locked)) begin
          errors++;
          $display("FAIL R8 pulse without lock fall actual=%0b expected=0", locked);
        end
      end
    end
    prev_locked = locked;
    prev_pulse = loss_pulse;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int l;
    int w;
    // R1: reset state
    at_cycle(4);
    chk("R1 locked in reset", locked, 1'b0);
    chk("R1 pulse in reset", loss_pulse, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    at_cycle(10);

    // R2/R5: first lock, MF=8, divide by 2
    w = WTK * 2;
    expect_ev(EV_LOCK, "R5 first lock");
    do_load(8, 1, 2, l);
    at_cycle(l + 16*w + w/2);
    chk("R5 not yet locked after 15 windows", locked, 1'b0);
    at_cycle(l + 17*w + w/2);
    chk("R2 locked on matching counts", locked, 1'b1);

    // R3: one dropped feedback edge while locked
    expect_ev(EV_LOSS, "R3 loss");
    at_cycle(l + 18*w + 3);
    skip_req = 1'b1;
    at_cycle(l + 18*w + w/2);
    chk("R3 still locked before window end", locked, 1'b1);
    at_cycle(l + 19*w + w/2);
    chk("R3 locked drops after miss", locked, 1'b0);

    // R6: a miss while unlocked restarts the streak, no pulse
    at_cycle(l + 25*w + 3);
    skip_req = 1'b1;
    at_cycle(l + 35*w + w/2);
    chk("R6 streak restarted, still unlocked", locked, 1'b0);
    expect_ev(EV_LOCK, "R5 relock");
    at_cycle(l + 41*w + w/2);
    chk("R5 not yet relocked", locked, 1'b0);
    at_cycle(l + 42*w + w/2);
    chk("R5 relocked after 16 matches", locked, 1'b1);

    // R4: MF=4 bypasses the count comparison
    do_load(4, 1, 0, l);
    at_cycle(l + w + w/2);
    chk("R7 load keeps lock", locked, 1'b1);
    at_cycle(l + 2*w + 3);
    skip_req = 1'b1;
    at_cycle(l + 4*w + w/2);
    chk("R4 miss ignored at MF=4", locked, 1'b1);

    // R7: MF=5 and DF=2 together, feedback follows the new divide
    w = WTK * 3;
    do_load(5, 2, 3, l);
    at_cycle(l + 3*w + w/2);
    chk("R7 new divide used, lock kept", locked, 1'b1);
    expect_ev(EV_LOSS, "R3 loss at MF=5");
    at_cycle(l + 4*w + 3);
    skip_req = 1'b1;
    at_cycle(l + 5*w + w/2);
    chk("R3 MF=5 detects miss", locked, 1'b0);
    expect_ev(EV_LOCK, "R5 relock at DF=2");
    at_cycle(l + 21*w + w/2);
    chk("R5 relock at DF=2", locked, 1'b1);

    // R7: divide factor changed but feedback does not follow
    w = WTK * 4;
    do_load(8, 3, 0, l);
    at_cycle(l + w + w/2);
    chk("R7 first window discarded", locked, 1'b1);
    expect_ev(EV_LOSS, "R7 loss after settle window");
    at_cycle(l + 2*w + w/2);
    chk("R7 loss in first checked window", locked, 1'b0);
    at_cycle(l + 6*w + w/2);
    chk("R6 persistent miss keeps unlocked", locked, 1'b0);

    // R4: switch to MF=2, mismatching feedback now counts as matched
    do_load(2, 3, 0, l);
    expect_ev(EV_LOCK, "R4 bypass relock");
    at_cycle(l + 16*w + w/2);
    chk("R4 bypass not yet locked", locked, 1'b0);
    at_cycle(l + 17*w + w/2);
    chk("R4 bypass locks on window count", locked, 1'b1);
    chk("R8 no pulse at end", loss_pulse, 1'b0);

    checks++;
    if (ev_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", ev_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule